// File: doc/BRIEF.md
# APB Control/Status Register File with Selectable Read Retiming

This block is a small bank of 32-bit control and status words reached through an APB4 completer port. It holds three kinds of word. Read-write words drive hardware outputs. Read-only words capture hardware inputs. Write-only words drive hardware outputs but return zero when read. The words sit at consecutive word addresses, in that order: read-write first, then read-only, then write-only. A decoder turns the word index into a one-hot select, and an OR-based readback tree gathers the selected word.

Two register stages on the read path can each be enabled by a parameter. The first splits the readback tree in half and registers both halves. The second registers the tree output in front of the APB response. Each stage adds one wait state to reads only.

Two more parameters control error reporting on PSLVERR. One reports accesses that hit no word. The other reports writes to read-only words and reads of write-only words. Reset polarity and the choice between synchronous and asynchronous reset are parameters too. The address width is at least the larger of ceil(log2(bytes in the bank)) and ceil(log2(bytes per word)) + 1. A narrower setting stops elaboration.

Top module: `apb_csr_block`

## Requirements
- R1: A write to a read-write word updates that word's slice of `rw_q` and is returned by a later read of the same address. Words that were not addressed hold their value.
- R2: `pstrb[b]` enables byte b (bits 8b+7..8b) of a write to a read-write or write-only word. Bytes with a clear strobe keep their old value.
- R3: Read-only words register their `ro_d` slice on every clock. A read returns the input as of an earlier edge. Writes to them change nothing.
- R4: A write to a write-only word updates its slice of `wo_q`. A read of it returns zero.
- R5: Word index is `paddr[AW-1:2]`. Bits 1:0 are ignored, so, for example, address 0x05 selects the same word as 0x04.
- R6: Writes complete in the first access cycle (PREADY high). Reads complete after 1 + RETIME_FANIN + RETIME_RESP access cycles.
- R7: With ERR_BAD_ADDR=1, an access whose index matches no word completes with PSLVERR high. Default map: indices 0..4 used, 0x14 and above unmapped.
- R8: With ERR_BAD_DIR=1, a write to a read-only word or a read of a write-only word completes with PSLVERR high.
- R9: With both error options at 0, PSLVERR stays low. Unmapped reads return zero. Unmapped and wrong-direction writes change no output.
- R10: All flops reset to zero. RST_LOW selects an active-low `reset`. RST_ASYNC selects whether reset acts at once or only at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset | input | 1 | Reset, polarity set by RST_LOW |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | AW | APB byte address |
| pwdata | input | DW | APB write data |
| pstrb | input | DW/8 | APB byte strobes |
| prdata | output | DW | APB read data, zero outside completing reads |
| pready | output | 1 | APB transfer completion |
| pslverr | output | 1 | APB error response |
| rw_q | output | N_RW*DW | Read-write word contents, word 0 in the low bits |
| ro_d | input | N_RO*DW | Hardware values for the read-only words |
| wo_q | output | N_WO*DW | Write-only word contents |

## Verification
The assertions assume the requester follows APB4: a setup cycle with PSEL alone, then PENABLE with address, direction and data held steady until PREADY. They also assume that reset is released away from a clock edge. The bench drives every transfer through one task that builds exactly this two-phase sequence, changes inputs one time unit after a rising edge, and releases reset the same way. Two configurations share the bus. One has both retiming stages, both error options and asynchronous active-low reset. The other has no retiming, no error reporting and synchronous active-high reset. A separate select line drives each one.

// File: rtl/apb_csr_pkg.sv
package apb_csr_pkg;

  typedef enum logic [1:0] {
    KIND_RW = 2'd0,
    KIND_RO = 2'd1,
    KIND_WO = 2'd2
  } csr_kind_e;

  // Smallest legal address width for a bank of nreg words of dw bits
  function automatic int addr_w_min(input int nreg, input int dw);
    int by_size;
    int by_word;
    by_size = $clog2(nreg * (dw / 8));
    by_word = $clog2(dw / 8) + 1;
    return (by_size > by_word) ? by_size : by_word;
  endfunction

  function automatic csr_kind_e kind_of(input int idx, input int n_rw, input int n_ro);
    if (idx < n_rw)        return KIND_RW;
    if (idx < n_rw + n_ro) return KIND_RO;
    return KIND_WO;
  endfunction

endpackage

// File: rtl/csr_dff.sv
module csr_dff #(
  parameter int W         = 1,
  parameter bit RST_ASYNC = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (RST_ASYNC) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/csr_decode.sv
module csr_decode
  import apb_csr_pkg::*;
#(
  parameter int IW   = 3,
  parameter int NREG = 5,
  parameter int N_RW = 2,
  parameter int N_RO = 2
) (
  input  logic [IW-1:0]   widx,
  output logic [NREG-1:0] hit,
  output logic            any_hit,
  output logic            ro_hit,
  output logic            wo_hit
);
  logic [NREG-1:0] ro_mask;
  logic [NREG-1:0] wo_mask;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_word
      assign hit[i]     = (widx == IW'(i));
      assign ro_mask[i] = (kind_of(i, N_RW, N_RO) == KIND_RO);
      assign wo_mask[i] = (kind_of(i, N_RW, N_RO) == KIND_WO);
    end
  endgenerate

  assign any_hit = |hit;
  assign ro_hit  = |(hit & ro_mask);
  assign wo_hit  = |(hit & wo_mask);
endmodule

// File: rtl/csr_regs.sv
module csr_regs #(
  parameter int DW        = 32,
  parameter int N_RW      = 2,
  parameter int N_RO      = 2,
  parameter int N_WO      = 1,
  parameter bit RST_ASYNC = 1'b1,
  localparam int NREG     = N_RW + N_RO + N_WO,
  localparam int SW       = DW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DW-1:0]      wdata,
  input  logic [SW-1:0]      strb,
  input  logic [NREG-1:0]    hit,
  input  logic [N_RO*DW-1:0] ro_d,
  output logic [N_RW*DW-1:0] rw_q,
  output logic [N_WO*DW-1:0] wo_q,
  output logic [NREG*DW-1:0] words
);
  logic [N_RO*DW-1:0] ro_q;

  generate
    for (genvar i = 0; i < N_RW; i++) begin : g_rw
      for (genvar b = 0; b < SW; b++) begin : g_byte
        csr_dff #(.W(8), .RST_ASYNC(RST_ASYNC)) u_byte (
          .clk(clk), .rst_n(rst_n),
          .en(wr_en & hit[i] & strb[b]),
          .d(wdata[8*b +: 8]),
          .q(rw_q[i*DW + 8*b +: 8])
        );
      end
      assign words[i*DW +: DW] = rw_q[i*DW +: DW];
    end

    for (genvar i = 0; i < N_RO; i++) begin : g_ro
      csr_dff #(.W(DW), .RST_ASYNC(RST_ASYNC)) u_word (
        .clk(clk), .rst_n(rst_n), .en(1'b1),
        .d(ro_d[i*DW +: DW]), .q(ro_q[i*DW +: DW])
      );
      assign words[(N_RW+i)*DW +: DW] = ro_q[i*DW +: DW];
    end

    for (genvar i = 0; i < N_WO; i++) begin : g_wo
      for (genvar b = 0; b < SW; b++) begin : g_byte
        csr_dff #(.W(8), .RST_ASYNC(RST_ASYNC)) u_byte (
          .clk(clk), .rst_n(rst_n),
          .en(wr_en & hit[N_RW+N_RO+i] & strb[b]),
          .d(wdata[8*b +: 8]),
          .q(wo_q[i*DW + 8*b +: 8])
        );
      end
      assign words[(N_RW+N_RO+i)*DW +: DW] = '0;
    end
  endgenerate

  // R1
  rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rw_q));

  // R4
  wo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wo_q));
endmodule

// File: rtl/csr_readback.sv
module csr_readback #(
  parameter int DW        = 32,
  parameter int NREG      = 5,
  parameter bit RETIME    = 1'b0,
  parameter bit RST_ASYNC = 1'b1,
  localparam int HALF     = (NREG + 1) / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic [NREG-1:0]    sel,
  input  logic [NREG*DW-1:0] words,
  output logic               out_vld,
  output logic [DW-1:0]      out_data
);
  logic [DW-1:0] lo_or;
  logic [DW-1:0] hi_or;
  logic [DW-1:0] lo_s;
  logic [DW-1:0] hi_s;

  always_comb begin
    lo_or = '0;
    hi_or = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel[i]) begin
        if (i < HALF) lo_or = lo_or | words[i*DW +: DW];
        else          hi_or = hi_or | words[i*DW +: DW];
      end
    end
  end

  generate
    if (RETIME) begin : g_cut
      csr_dff #(.W(1), .RST_ASYNC(RST_ASYNC)) u_vld (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .d(in_vld), .q(out_vld));
      csr_dff #(.W(2*DW), .RST_ASYNC(RST_ASYNC)) u_half (
        .clk(clk), .rst_n(rst_n), .en(in_vld),
        .d({hi_or, lo_or}), .q({hi_s, lo_s}));

      // R6
      fanin_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    end else begin : g_flat
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst_n;
      assign out_vld = in_vld;
      assign lo_s    = lo_or;
      assign hi_s    = hi_or;
    end
  endgenerate

  assign out_data = lo_s | hi_s;
endmodule

// File: rtl/apb_csr_block.sv
module apb_csr_block
  import apb_csr_pkg::*;
#(
  parameter int DW           = 32,
  parameter int N_RW         = 2,
  parameter int N_RO         = 2,
  parameter int N_WO         = 1,
  parameter int AW           = addr_w_min(N_RW + N_RO + N_WO, DW),
  parameter bit RETIME_FANIN = 1'b0,
  parameter bit RETIME_RESP  = 1'b0,
  parameter bit ERR_BAD_ADDR = 1'b0,
  parameter bit ERR_BAD_DIR  = 1'b0,
  parameter bit RST_LOW      = 1'b1,
  parameter bit RST_ASYNC    = 1'b1
) (
  input  logic               clk,
  input  logic               reset,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [AW-1:0]      paddr,
  input  logic [DW-1:0]      pwdata,
  input  logic [DW/8-1:0]    pstrb,
  output logic [DW-1:0]      prdata,
  output logic               pready,
  output logic               pslverr,
  output logic [N_RW*DW-1:0] rw_q,
  input  logic [N_RO*DW-1:0] ro_d,
  output logic [N_WO*DW-1:0] wo_q
);
  localparam int NREG   = N_RW + N_RO + N_WO;
  localparam int LSB    = $clog2(DW / 8);
  localparam int IW     = AW - LSB;
  localparam int RD_LAT = int'(RETIME_FANIN) + int'(RETIME_RESP);

  generate
    if (AW < addr_w_min(NREG, DW)) begin : g_bad_aw
      $error("apb_csr_block: AW below the minimum for this bank");
    end
  endgenerate

  logic rst_n;
  assign rst_n = RST_LOW ? reset : ~reset;

  logic            unused_low;
  logic [NREG-1:0] hit;
  logic            any_hit, ro_hit, wo_hit;
  logic            access, launch;
  logic            rd_wait_d, rd_wait_q;
  logic            rb_vld, rsp_vld;
  logic [DW-1:0]   rb_data, rsp_data;
  logic [NREG*DW-1:0] words;
  logic            bad_addr, bad_dir;

  assign unused_low = ^paddr[LSB-1:0];

  csr_decode #(.IW(IW), .NREG(NREG), .N_RW(N_RW), .N_RO(N_RO)) u_dec (
    .widx(paddr[AW-1:LSB]), .hit(hit), .any_hit(any_hit),
    .ro_hit(ro_hit), .wo_hit(wo_hit));

  assign access = psel & penable;
  assign launch = access & ~pwrite & ~rd_wait_q;

  csr_regs #(.DW(DW), .N_RW(N_RW), .N_RO(N_RO), .N_WO(N_WO),
             .RST_ASYNC(RST_ASYNC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(access & pwrite),
    .wdata(pwdata), .strb(pstrb), .hit(hit), .ro_d(ro_d),
    .rw_q(rw_q), .wo_q(wo_q), .words(words));

  csr_readback #(.DW(DW), .NREG(NREG), .RETIME(RETIME_FANIN),
                 .RST_ASYNC(RST_ASYNC)) u_rb (
    .clk(clk), .rst_n(rst_n), .in_vld(launch), .sel(hit), .words(words),
    .out_vld(rb_vld), .out_data(rb_data));

  generate
    if (RETIME_RESP) begin : g_rsp
      csr_dff #(.W(1), .RST_ASYNC(RST_ASYNC)) u_vld (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .d(rb_vld), .q(rsp_vld));
      csr_dff #(.W(DW), .RST_ASYNC(RST_ASYNC)) u_dat (
        .clk(clk), .rst_n(rst_n), .en(rb_vld), .d(rb_data), .q(rsp_data));
    end else begin : g_norsp
      assign rsp_vld  = rb_vld;
      assign rsp_data = rb_data;
    end
  endgenerate

  // Outstanding-read flag: next state, then register
  always_comb begin
    rd_wait_d = rd_wait_q;
    if (rsp_vld)                     rd_wait_d = 1'b0;
    else if (launch && RD_LAT != 0)  rd_wait_d = 1'b1;
  end

  csr_dff #(.W(1), .RST_ASYNC(RST_ASYNC)) u_wait (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .d(rd_wait_d), .q(rd_wait_q));

  assign bad_addr = ~any_hit;
  assign bad_dir  = pwrite ? ro_hit : wo_hit;
  assign pready   = access & (pwrite | rsp_vld);
  assign pslverr  = pready & ((ERR_BAD_ADDR & bad_addr) | (ERR_BAD_DIR & bad_dir));
  assign prdata   = (pready & ~pwrite) ? rsp_data : '0;

  // R5
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R6
  wr_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && pwrite) |-> pready);

  // R6
  ready_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pready |-> (psel && penable));

  // R6
  rd_first_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && RD_LAT != 0) |-> !pready);

  // R7
  err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> pready);

  // R9
  err_mapped_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pready && any_hit && !ro_hit && !wo_hit) |-> !pslverr);
endmodule

// File: tb/tb_apb_csr_block.sv
module tb_apb_csr_block;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, rst_p;
  logic        psel_a, psel_b, penable, pwrite;
  logic [4:0]  paddr;
  logic [31:0] pwdata;
  logic [3:0]  pstrb;
  logic [63:0] ro_d;
  logic [31:0] prdata_a, prdata_b;
  logic        pready_a, pready_b, pslverr_a, pslverr_b;
  logic [63:0] rw_a, rw_b;
  logic [31:0] wo_a, wo_b;

  int n_chk  = 0;
  int n_fail = 0;

  // Fully featured: both stages, both error options, async active-low reset
  apb_csr_block #(.RETIME_FANIN(1'b1), .RETIME_RESP(1'b1),
                  .ERR_BAD_ADDR(1'b1), .ERR_BAD_DIR(1'b1),
                  .RST_LOW(1'b1), .RST_ASYNC(1'b1)) dut (
    .clk(clk), .reset(rst_n), .psel(psel_a), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
    .prdata(prdata_a), .pready(pready_a), .pslverr(pslverr_a),
    .rw_q(rw_a), .ro_d(ro_d), .wo_q(wo_a));

  // Plain: no stages, no errors, sync active-high reset
  apb_csr_block #(.RETIME_FANIN(1'b0), .RETIME_RESP(1'b0),
                  .ERR_BAD_ADDR(1'b0), .ERR_BAD_DIR(1'b0),
                  .RST_LOW(1'b0), .RST_ASYNC(1'b0)) dut_b (
    .clk(clk), .reset(rst_p), .psel(psel_b), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
    .prdata(prdata_b), .pready(pready_b), .pslverr(pslverr_b),
    .rw_q(rw_b), .ro_d(ro_d), .wo_q(wo_b));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One APB transfer on configuration a (which=0) or b (which=1)
  task automatic xfer(input bit which, input bit wr, input logic [4:0] a,
                      input logic [31:0] d, input logic [3:0] s,
                      output logic [31:0] rd, output logic err, output int cyc);
    @(posedge clk); #1;
    psel_a = !which; psel_b = which; penable = 1'b0;
    pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    @(posedge clk); #1;
    penable = 1'b1;
    cyc = 0;
    rd = '0; err = 1'b0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (which ? pready_b : pready_a) begin
        rd  = which ? prdata_b : prdata_a;
        err = which ? pslverr_b : pslverr_a;
        break;
      end
      if (cyc > 20) break;
    end
    @(posedge clk); #1;
    psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset rw_a", rw_a, 64'h0);
    chk("R10 reset rw_b", rw_b, 64'h0);
    chk("R10 reset wo_a", {32'h0, wo_a}, 64'h0);
    chk("R6 idle pready", {62'h0, pready_a, pready_b}, 64'h0);
  endtask

  task automatic t_rw();
    logic [31:0] rd; logic e; int c;
    xfer(0, 1, 5'h00, 32'h11223344, 4'hF, rd, e, c);
    chk("R6 write cycles a", c, 1);
    xfer(1, 1, 5'h00, 32'h55667788, 4'hF, rd, e, c);
    chk("R6 write cycles b", c, 1);
    chk("R1 rw_q port a", rw_a, 64'h0000_0000_1122_3344);
    chk("R1 rw_q port b", rw_b, 64'h0000_0000_5566_7788);
    xfer(0, 0, 5'h00, 0, 4'hF, rd, e, c);
    chk("R1 read back a", rd, 32'h11223344);
    chk("R6 read cycles with two stages", c, 3);
    xfer(1, 0, 5'h00, 0, 4'hF, rd, e, c);
    chk("R1 read back b", rd, 32'h55667788);
    chk("R6 read cycles no stage", c, 1);
    chk("R9 err low b", e, 0);
  endtask

  task automatic t_strobe();
    logic [31:0] rd; logic e; int c;
    xfer(0, 1, 5'h00, 32'hAABBCCDD, 4'b0101, rd, e, c);
    xfer(0, 0, 5'h00, 0, 4'hF, rd, e, c);
    chk("R2 partial strobe", rd, 32'h11BB33DD);
    xfer(0, 1, 5'h10, 32'hFFFFFFFF, 4'b1000, rd, e, c);
    chk("R2 wo strobe", wo_a, 32'hFF000000);
  endtask

  task automatic t_ro();
    logic [31:0] rd; logic e; int c;
    ro_d = 64'hDEAD0002_CAFE0001;
    xfer(0, 0, 5'h08, 0, 4'hF, rd, e, c);
    chk("R3 ro word0 a", rd, 32'hCAFE0001);
    xfer(1, 0, 5'h0C, 0, 4'hF, rd, e, c);
    chk("R3 ro word1 b", rd, 32'hDEAD0002);
    xfer(1, 1, 5'h08, 32'h0, 4'hF, rd, e, c);
    chk("R9 ro write no err b", e, 0);
    xfer(1, 0, 5'h08, 0, 4'hF, rd, e, c);
    chk("R3 ro write ignored", rd, 32'hCAFE0001);
    xfer(0, 1, 5'h08, 32'h0, 4'hF, rd, e, c);
    chk("R8 ro write err a", e, 1);
  endtask

  task automatic t_wo();
    logic [31:0] rd; logic e; int c;
    xfer(1, 1, 5'h10, 32'h0BADF00D, 4'hF, rd, e, c);
    chk("R4 wo_q port b", wo_b, 32'h0BADF00D);
    xfer(1, 0, 5'h10, 0, 4'hF, rd, e, c);
    chk("R4 wo read zero b", {rd, 31'h0, e}, 64'h0);
    xfer(0, 0, 5'h10, 0, 4'hF, rd, e, c);
    chk("R8 wo read err a", {rd, 31'h0, e}, 64'h1);
    xfer(0, 1, 5'h10, 32'h12345678, 4'hF, rd, e, c);
    chk("R8 wo write ok a", e, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] rd; logic e; int c;
    xfer(1, 0, 5'h14, 0, 4'hF, rd, e, c);
    chk("R9 unmapped read b", {rd, 31'h0, e}, 64'h0);
    xfer(1, 1, 5'h1C, 32'hFFFFFFFF, 4'hF, rd, e, c);
    chk("R9 unmapped write rw_b", rw_b, 64'h0000_0000_5566_7788);
    chk("R9 unmapped write wo_b", {32'h0, wo_b}, 64'h0BADF00D);
    xfer(0, 0, 5'h18, 0, 4'hF, rd, e, c);
    chk("R7 unmapped read err a", {rd, 31'h0, e}, 64'h1);
    xfer(0, 1, 5'h14, 32'h1, 4'hF, rd, e, c);
    chk("R7 unmapped write err a", e, 1);
    chk("R7 write cycles a", c, 1);
  endtask

  task automatic t_alias();
    logic [31:0] rd; logic e; int c;
    xfer(0, 1, 5'h06, 32'hA5A5A5A5, 4'hF, rd, e, c);
    chk("R5 low bits write", rw_a, 64'hA5A5A5A5_11BB33DD);
    xfer(0, 0, 5'h05, 0, 4'hF, rd, e, c);
    chk("R5 low bits read", rd, 32'hA5A5A5A5);
  endtask

  task automatic t_reset_modes();
    @(posedge clk); #1;
    rst_p = 1'b1;
    #1;
    chk("R10 sync reset waits for edge", rw_b, 64'h0000_0000_5566_7788);
    @(posedge clk); #1;
    chk("R10 sync reset at edge", rw_b, 64'h0);
    chk("R10 other instance untouched", rw_a, 64'hA5A5A5A5_11BB33DD);
    @(posedge clk); #1;
    rst_p = 1'b0;
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    chk("R10 async reset immediate", rw_a, 64'h0);
    chk("R10 async reset wo", {32'h0, wo_a}, 64'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; rst_p = 1'b1;
    psel_a = 0; psel_b = 0; penable = 0; pwrite = 0;
    paddr = '0; pwdata = '0; pstrb = '0; ro_d = '0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1; rst_p = 1'b0;
    @(negedge clk);
    t_reset();
    t_rw();
    t_strobe();
    t_ro();
    t_wo();
    t_unmapped();
    t_alias();
    t_reset_modes();
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule